// File: doc/BRIEF.md
# Global-History Two-Bit Direction Predictor

This block guesses whether a conditional branch will be taken. A short shift register holds the most recent branch directions. Its value selects one entry in a small table of two-bit saturating counters. The top bit of the selected counter gives the guess. When a front end asks for a prediction, the block returns two things: the guessed direction, and the history value that produced it. The history value acts as a checkpoint. In the same clock edge, the guessed direction is shifted into the history, so the next branch sees the speculative path.

When the branch resolves, the pipeline sends back three values: the checkpoint, the direction it was told, and the direction that actually happened. The block uses the checkpoint to find the counter that made the guess, and moves that counter toward the actual outcome. If the guess was wrong, the history is rebuilt from the checkpoint with the real outcome appended. Any speculative bits that followed are thrown away.

The history width, the counter width and the reset value of the counters are parameters. The defaults are 3 history bits, 8 entries and 2-bit counters that start at weak not-taken.

Top module: `ghist_dir_predictor`

## Requirements
- R1: Reset clears the history to 000. It sets every counter to 01 (weak not-taken), so right after reset the block predicts not-taken and returns checkpoint 000.
- R2: `pred_snap` always equals the current history. `pred_taken` equals bit 1 (the most significant bit) of the counter indexed by that history. Counter encodings: 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken.
- R3: A prediction request with no mispredict in the same cycle shifts `pred_taken` into bit 0 of the history. The old bits move one place toward bit 2 and the old bit 2 is dropped. The new history shows at `pred_snap` in the next cycle.
- R4: A resolution with `res_taken`=1 increments the counter at index `res_snap`, and the counter stays at 11 once it is there.
- R5: A resolution with `res_taken`=0 decrements the counter at index `res_snap`, and the counter stays at 00 once it is there.
- R6: A resolution with `res_pred` different from `res_taken` sets the history to {`res_snap`[1:0], `res_taken`} in the next cycle.
- R7: A cycle with no prediction request and no mispredict leaves the history unchanged. This includes a cycle with a correctly predicted resolution.
- R8: When a prediction request and a mispredict fall in the same cycle, the mispredict repair sets the history and the speculative shift is discarded. The prediction returned in that cycle still comes from the pre-edge history and table.
- R9: A resolution changes only the counter at index `res_snap`. All other counters keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_req | input | 1 | Prediction request; the history shifts at the next edge |
| pred_taken | output | 1 | Predicted direction for the current history |
| pred_snap | output | 3 | History checkpoint used for this prediction |
| res_valid | input | 1 | A branch outcome is being reported |
| res_snap | input | 3 | Checkpoint that was returned with that branch's prediction |
| res_pred | input | 1 | Direction that was predicted for that branch |
| res_taken | input | 1 | Actual direction of that branch |

## Verification
Directed sequences first drive one counter up into its top state and then down into its bottom state. This separates correct saturation from wrap-around. Three other patterns are tried in turn: a run of predictions alone, a mispredict alone, and a mispredict in the same cycle as a prediction. Comparing them shows that the speculative shift, the repair and the priority between the two are each right. A long seeded random mix then sends resolutions with arbitrary checkpoints against a bench model of the history and all eight counters. Any update that lands on the wrong counter, or that reads a counter after its update instead of before, later shows up as a wrong `pred_taken`.

// File: rtl/ghp_pkg.sv
package ghp_pkg;

   localparam int unsigned GHP_HIST_W_DEF = 3;
   localparam int unsigned GHP_CTR_W_DEF  = 2;

   typedef enum logic [1:0] {
      DIR_STRONG_NT = 2'b00,
      DIR_WEAK_NT   = 2'b01,
      DIR_WEAK_T    = 2'b10,
      DIR_STRONG_T  = 2'b11
   } dir_state_e;

   localparam logic [1:0] GHP_CTR_INIT_DEF = DIR_WEAK_NT;

   function automatic logic is_mispredict(input logic valid,
                                          input logic guessed,
                                          input logic actual);
      return valid && (guessed != actual);
   endfunction

endpackage

// File: rtl/ghp_history.sv
module ghp_history #(
   parameter int unsigned HIST_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spec_en,
   input  logic              spec_bit,
   input  logic              fix_en,
   input  logic [HIST_W-1:0] fix_snap,
   input  logic              fix_bit,
   output logic [HIST_W-1:0] hist_q
);

   logic [HIST_W-1:0] hist_d;

   generate
      if (HIST_W < 2) begin : g_bad_width
         $error("ghp_history: HIST_W must be at least 2");
      end
   endgenerate

   // A repair outranks a speculative shift.
   always_comb begin
      hist_d = hist_q;
      if (fix_en) begin
         hist_d = {fix_snap[HIST_W-2:0], fix_bit};
      end else if (spec_en) begin
         hist_d = {hist_q[HIST_W-2:0], spec_bit};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hist_q <= '0;
      end else begin
         hist_q <= hist_d;
      end
   end

endmodule

// File: rtl/ghp_counter_cell.sv
module ghp_counter_cell #(
   parameter int unsigned           CTR_W    = 2,
   parameter logic [CTR_W-1:0]      CTR_INIT = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             upd_en,
   input  logic             upd_up,
   output logic [CTR_W-1:0] cnt_q
);

   localparam logic [CTR_W-1:0] CNT_MAX = {CTR_W{1'b1}};
   localparam logic [CTR_W-1:0] CNT_MIN = '0;
   localparam logic [CTR_W-1:0] CNT_ONE = CTR_W'(1);

   logic [CTR_W-1:0] cnt_d;

   always_comb begin
      cnt_d = cnt_q;
      if (upd_en) begin
         if (upd_up) begin
            if (cnt_q != CNT_MAX) cnt_d = cnt_q + CNT_ONE;
         end else begin
            if (cnt_q != CNT_MIN) cnt_d = cnt_q - CNT_ONE;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= CTR_INIT;
      end else begin
         cnt_q <= cnt_d;
      end
   end

endmodule

// File: rtl/ghp_pattern_table.sv
module ghp_pattern_table #(
   parameter int unsigned      IDX_W       = 3,
   parameter int unsigned      CTR_W       = 2,
   parameter logic [CTR_W-1:0] CTR_INIT    = 1,
   parameter bit               ONEHOT_READ = 1'b0
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [IDX_W-1:0]              rd_idx,
   output logic [CTR_W-1:0]              rd_cnt,
   input  logic                          wr_en,
   input  logic [IDX_W-1:0]              wr_idx,
   input  logic                          wr_up,
   output logic [(CTR_W<<IDX_W)-1:0]     cnt_flat
);

   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [CTR_W-1:0] cnt_arr [DEPTH];

   generate
      if (CTR_W < 1) begin : g_bad_ctr
         $error("ghp_pattern_table: CTR_W must be at least 1");
      end

      for (genvar e = 0; e < DEPTH; e++) begin : g_entry
         logic hit_w;
         assign hit_w = wr_en && (wr_idx == IDX_W'(e));

         ghp_counter_cell #(
            .CTR_W    (CTR_W),
            .CTR_INIT (CTR_INIT)
         ) u_cell (
            .clk    (clk),
            .rst_n  (rst_n),
            .upd_en (hit_w),
            .upd_up (wr_up),
            .cnt_q  (cnt_arr[e])
         );

         assign cnt_flat[e*CTR_W +: CTR_W] = cnt_arr[e];
      end

      if (ONEHOT_READ) begin : g_rd_andor
         always_comb begin
            rd_cnt = '0;
            for (int k = 0; k < DEPTH; k++) begin
               rd_cnt = rd_cnt | (cnt_arr[k] & {CTR_W{rd_idx == IDX_W'(k)}});
            end
         end
      end else begin : g_rd_mux
         assign rd_cnt = cnt_arr[rd_idx];
      end
   endgenerate

endmodule

// File: rtl/ghist_dir_predictor.sv
module ghist_dir_predictor
   import ghp_pkg::*;
#(
   parameter int unsigned      HIST_W      = GHP_HIST_W_DEF,
   parameter int unsigned      CTR_W       = GHP_CTR_W_DEF,
   parameter logic [CTR_W-1:0] CTR_INIT    = CTR_W'(GHP_CTR_INIT_DEF),
   parameter bit               ONEHOT_READ = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pred_req,
   output logic              pred_taken,
   output logic [HIST_W-1:0] pred_snap,
   input  logic              res_valid,
   input  logic [HIST_W-1:0] res_snap,
   input  logic              res_pred,
   input  logic              res_taken
);

   localparam int unsigned FLAT_W = CTR_W << HIST_W;

   logic [HIST_W-1:0] hist_q;
   logic [CTR_W-1:0]  sel_cnt;
   logic [FLAT_W-1:0] cnt_flat;
   logic              mispred;

   generate
      if (HIST_W < 2 || HIST_W > 10) begin : g_bad_hist
         $error("ghist_dir_predictor: HIST_W out of range 2..10");
      end
      if (CTR_W < 1 || CTR_W > 8) begin : g_bad_ctr
         $error("ghist_dir_predictor: CTR_W out of range 1..8");
      end
   endgenerate

   assign mispred = is_mispredict(res_valid, res_pred, res_taken);

   ghp_history #(
      .HIST_W (HIST_W)
   ) u_hist (
      .clk      (clk),
      .rst_n    (rst_n),
      .spec_en  (pred_req),
      .spec_bit (pred_taken),
      .fix_en   (mispred),
      .fix_snap (res_snap),
      .fix_bit  (res_taken),
      .hist_q   (hist_q)
   );

   ghp_pattern_table #(
      .IDX_W       (HIST_W),
      .CTR_W       (CTR_W),
      .CTR_INIT    (CTR_INIT),
      .ONEHOT_READ (ONEHOT_READ)
   ) u_pht (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_idx   (hist_q),
      .rd_cnt   (sel_cnt),
      .wr_en    (res_valid),
      .wr_idx   (res_snap),
      .wr_up    (res_taken),
      .cnt_flat (cnt_flat)
   );

   assign pred_taken = sel_cnt[CTR_W-1];
   assign pred_snap  = hist_q;

endmodule

// File: rtl/ghist_dir_predictor_chk.sv
module ghist_dir_predictor_chk #(
   parameter int unsigned HIST_W = 3,
   parameter int unsigned CTR_W  = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       pred_req,
   input logic                       pred_taken,
   input logic [HIST_W-1:0]          pred_snap,
   input logic                       res_valid,
   input logic [HIST_W-1:0]          res_snap,
   input logic                       res_pred,
   input logic                       res_taken,
   input logic [(CTR_W<<HIST_W)-1:0] cnt_flat
);

   localparam logic [CTR_W-1:0] C_MAX = {CTR_W{1'b1}};

   logic              bad;
   logic [CTR_W-1:0]  cur_ctr;
   logic [CTR_W-1:0]  ctr_at_prev;
   logic [HIST_W-1:0] prev_idx;

   assign bad         = res_valid && (res_pred != res_taken);
   assign cur_ctr     = cnt_flat[res_snap*CTR_W +: CTR_W];
   assign ctr_at_prev = cnt_flat[prev_idx*CTR_W +: CTR_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_idx <= '0;
      else        prev_idx <= res_snap;
   end

   // R1
   a_r1_reset_hist: assert property (@(posedge clk)
      !rst_n |=> (pred_snap == '0));

   // R3
   a_r3_spec_shift: assert property (@(posedge clk) disable iff (!rst_n)
      (pred_req && !bad) |=>
         (pred_snap == {$past(pred_snap[HIST_W-2:0]), $past(pred_taken)}));

   // R6 and R8
   a_r6_repair: assert property (@(posedge clk) disable iff (!rst_n)
      bad |=> (pred_snap == {$past(res_snap[HIST_W-2:0]), $past(res_taken)}));

   // R7
   a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pred_req && !bad) |=> $stable(pred_snap));

   // R4
   a_r4_count_up: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && cur_ctr != C_MAX) |=>
         (ctr_at_prev == CTR_W'($past(cur_ctr) + 1'b1)));

   a_r4_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_taken && cur_ctr == C_MAX) |=> (ctr_at_prev == C_MAX));

   // R5
   a_r5_count_down: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_taken && cur_ctr != '0) |=>
         (ctr_at_prev == CTR_W'($past(cur_ctr) - 1'b1)));

   a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && !res_taken && cur_ctr == '0) |=> (ctr_at_prev == '0));

   // R9
   a_r9_quiet_table: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> $stable(cnt_flat));

endmodule

bind ghist_dir_predictor ghist_dir_predictor_chk #(
   .HIST_W (HIST_W),
   .CTR_W  (CTR_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .pred_req   (pred_req),
   .pred_taken (pred_taken),
   .pred_snap  (pred_snap),
   .res_valid  (res_valid),
   .res_snap   (res_snap),
   .res_pred   (res_pred),
   .res_taken  (res_taken),
   .cnt_flat   (cnt_flat)
);

// File: tb/ghist_dir_predictor_tb.sv
module ghist_dir_predictor_tb;

   localparam int CLK_PERIOD = 10;
   localparam int HW         = 3;
   localparam int N_RAND     = 3000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          pred_req = 1'b0;
   logic          pred_taken;
   logic [HW-1:0] pred_snap;
   logic          res_valid = 1'b0;
   logic [HW-1:0] res_snap = '0;
   logic          res_pred = 1'b0;
   logic          res_taken = 1'b0;

   int n_checks = 0;
   int n_fails  = 0;

   logic [HW-1:0] hist_m;
   logic [1:0]    ctr_m [8];

   always #(CLK_PERIOD/2) clk = ~clk;

   ghist_dir_predictor u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .pred_req   (pred_req),
      .pred_taken (pred_taken),
      .pred_snap  (pred_snap),
      .res_valid  (res_valid),
      .res_snap   (res_snap),
      .res_pred   (res_pred),
      .res_taken  (res_taken)
   );

   function automatic logic [1:0] sat_next(input logic [1:0] c, input logic up);
      if (up)  return (c == 2'b11) ? c : c + 2'b01;
      return (c == 2'b00) ? c : c - 2'b01;
   endfunction

   task automatic check_now(input string tag);
      n_checks++;
      if (pred_snap !== hist_m) begin
         n_fails++;
         $display("FAIL %s pred_snap actual=%b expected=%b", tag, pred_snap, hist_m);
      end
      n_checks++;
      if (pred_taken !== ctr_m[hist_m][1]) begin
         n_fails++;
         $display("FAIL %s pred_taken actual=%b expected=%b", tag, pred_taken,
                  ctr_m[hist_m][1]);
      end
   endtask

   // Called at a falling edge: checks the outputs, drives one cycle, advances model.
   task automatic step(input string tag, input logic pr, input logic rv,
                       input logic [HW-1:0] rs, input logic rp, input logic rt);
      logic guess;
      check_now(tag);
      pred_req  = pr;
      res_valid = rv;
      res_snap  = rs;
      res_pred  = rp;
      res_taken = rt;
      guess = ctr_m[hist_m][1];
      if (rv) ctr_m[rs] = sat_next(ctr_m[rs], rt);
      if (rv && (rp != rt))  hist_m = {rs[HW-2:0], rt};
      else if (pr)           hist_m = {hist_m[HW-2:0], guess};
      @(negedge clk);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_fails++;
      n_checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

   initial begin
      void'($urandom(32'd7321));
      hist_m = '0;
      for (int i = 0; i < 8; i++) ctr_m[i] = 2'b01;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, then a few idle cycles (R7)
      step("R1", 0, 0, 3'd0, 0, 0);
      step("R7", 0, 0, 3'd0, 0, 0);

      // R4: drive entry 0 up to saturation with correct resolutions
      for (int i = 0; i < 4; i++) step("R4", 0, 1, 3'd0, 1, 1);
      step("R4", 0, 0, 3'd0, 0, 0);
      // R5: drive entry 0 down to saturation
      for (int i = 0; i < 5; i++) step("R5", 0, 1, 3'd0, 0, 0);
      step("R5", 0, 0, 3'd0, 0, 0);

      // R3: predictions shift the guessed direction in
      step("R3", 1, 0, 3'd0, 0, 0);
      step("R3", 0, 1, 3'd0, 1, 1);
      step("R3", 0, 1, 3'd0, 1, 1);
      step("R3", 1, 0, 3'd0, 0, 0);
      step("R3", 1, 0, 3'd0, 0, 0);
      step("R2", 0, 0, 3'd0, 0, 0);

      // R6: mispredict alone
      step("R6", 0, 1, 3'b101, 0, 1);
      step("R6", 0, 0, 3'd0, 0, 0);

      // R8: prediction and mispredict together
      step("R8", 1, 1, 3'b110, 1, 0);
      step("R8", 0, 0, 3'd0, 0, 0);

      // R9: update a different entry and confirm the current one is untouched
      step("R9", 0, 1, 3'b011, 1, 1);
      step("R9", 0, 1, 3'b011, 1, 1);
      step("R9", 0, 0, 3'd0, 0, 0);

      // R2/R9: seeded random mix
      for (int i = 0; i < N_RAND; i++) begin
         logic pr, rv, rp, rt;
         logic [HW-1:0] rs;
         pr = ($urandom % 100) < 50;
         rv = ($urandom % 100) < 45;
         rs = HW'($urandom);
         rt = $urandom % 2;
         rp = (($urandom % 100) < 70) ? rt : ~rt;
         step("R2/R9 random", pr, rv, rs, rp, rt);
      end
      step("R2", 0, 0, 3'd0, 0, 0);

      $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
      $finish;
   end

endmodule